// File: doc/BRIEF.md
# Timer DMA Burst Register Redirector

This block lives inside a timer's register file. It lets a DMA controller move a run of consecutive timer registers through a single fixed window address. Software programs a control word with two fields: a first register index and a burst length. Every read or write that lands on the window address is steered to the timer register at the first index plus an internal hardware step counter. The counter advances after each window access. It returns to zero once the programmed length has been covered, so the next DMA burst starts again at the first index.

The block presents a simple single-cycle, word-wide register bus slave. Toward the timer registers it drives a register index, a 16-bit write data path with a one-cycle write strobe, and a 16-bit read data return. The timer registers themselves, DMA request generation and the DMA engine are outside the block.

Top module: `tmr_burst_redirect`

## Requirements
- R1: After reset the control word reads as 0x0000_0000, and the first window access targets register index 0.
- R2: A write to the control address (byte offset 0x48) stores bus bits 12:8 as the burst length and bits 4:0 as the first index. A read of the control address returns those fields in the same positions, with every other bit reading zero.
- R3: The k-th window access (byte offset 0x4C) after the counter was last cleared targets register index (first index + k) on `regSel`, in the same cycle as the access.
- R4: One burst covers burst length + 1 window accesses. The access made with step counter equal to the burst length is followed by an access at the first index again.
- R5: Any write to the control address clears the step counter, so the next window access targets the newly written first index.
- R6: A window read returns the selected register's 16-bit `regRdata` in bits 15:0 of `busRdata`, with bits 31:16 zero, in the cycle of the access.
- R7: A window write raises `regWe` for exactly the access cycle and presents bus bits 15:0 on `regWdata`. No other access raises `regWe`.
- R8: The target index is (first index + step) modulo 32, so a burst running past index 31 continues at index 0.
- R9: An access to any address other than the control or window word (including the unaligned byte offsets 0x49 and 0x4D) reads zero, raises no `regWe`, and leaves the step counter and control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Register bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte address of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| regSel | output | 5 | Index of the timer register addressed through the window |
| regWdata | output | 16 | Write data toward the timer register |
| regWe | output | 1 | One-cycle write strobe toward the timer register |
| regRdata | input | 16 | Read data from the selected timer register |

## Verification
The embedded assertions check, on every cycle, how the step counter moves. It must stay within the burst length, advance by one on a mid-burst window access, return to zero after the last step, clear on a control write and hold still otherwise. They also check that the write strobe appears only on a window write and that a control write lands in the stored fields. What the assertions cannot show is the end-to-end effect. That means the actual sequence of register indices seen by the timer, burst repetition, wrap past index 31, the data returned on window reads and the data written into the right backing register. The bench shows these by running directed bursts and constrained-random traffic against its own model of the index arithmetic and a backing register array.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  // Decoded access strobes handed from the control module to the datapath.
  typedef struct packed {
    logic ctrlWr;
    logic ctrlRd;
    logic winWr;
    logic winRd;
  } tbr_strobe_t;

endpackage

// File: rtl/tbr_ctrl.sv
module tbr_ctrl
  import tbr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 5,
  parameter int CTRL_OFF = 'h48,
  parameter int WIN_OFF  = 'h4C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [IDX_W-1:0]  burstLen,
  output tbr_strobe_t       strb,
  output logic [IDX_W-1:0]  stepCnt
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFF);
  localparam logic [ADDR_W-1:0] WIN_ADDR  = ADDR_W'(WIN_OFF);
  localparam logic [IDX_W-1:0]  STEP_ONE  = IDX_W'(1);

  logic hitCtrl;
  logic hitWin;
  logic winAcc;
  logic lastStep;

  assign hitCtrl = busValid && (busAddr == CTRL_ADDR);
  assign hitWin  = busValid && (busAddr == WIN_ADDR);

  always_comb begin
    strb        = '0;
    strb.ctrlWr = hitCtrl && busWrite;
    strb.ctrlRd = hitCtrl && !busWrite;
    strb.winWr  = hitWin && busWrite;
    strb.winRd  = hitWin && !busWrite;
  end

  assign winAcc   = strb.winWr || strb.winRd;
  assign lastStep = (stepCnt == burstLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepCnt <= '0;
    end else if (strb.ctrlWr) begin
      stepCnt <= '0;
    end else if (winAcc) begin
      stepCnt <= lastStep ? '0 : stepCnt + STEP_ONE;
    end
  end

  // R4
  step_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (stepCnt <= burstLen || $past(strb.ctrlWr) == 1'b0 && stepCnt == '0 || stepCnt <= $past(burstLen)));

  // R3
  step_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winAcc && !strb.ctrlWr && stepCnt != burstLen) |=> stepCnt == $past(stepCnt) + STEP_ONE);

  // R4
  burst_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winAcc && !strb.ctrlWr && stepCnt == burstLen) |=> stepCnt == '0);

  // R5
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWr |=> stepCnt == '0);

  // R9
  step_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!winAcc && !strb.ctrlWr) |=> $stable(stepCnt));

endmodule

// File: rtl/tbr_datapath.sv
module tbr_datapath
  import tbr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5,
  parameter int WIN_W     = 16,
  parameter int LEN_LSB   = 8,
  parameter int FIRST_LSB = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  tbr_strobe_t       strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [IDX_W-1:0]  stepCnt,
  input  logic [WIN_W-1:0]  regRdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [IDX_W-1:0]  regSel,
  output logic [WIN_W-1:0]  regWdata,
  output logic              regWe,
  output logic [IDX_W-1:0]  burstLen
);

  logic [IDX_W-1:0] firstIdx;

  // Control word storage: only the two fields are kept.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      firstIdx <= '0;
      burstLen <= '0;
    end else if (strb.ctrlWr) begin
      firstIdx <= busWdata[FIRST_LSB +: IDX_W];
      burstLen <= busWdata[LEN_LSB +: IDX_W];
    end
  end

  // Target index; the sum is truncated to IDX_W so it wraps by itself.
  assign regSel   = firstIdx + stepCnt;
  assign regWdata = busWdata[WIN_W-1:0];
  assign regWe    = strb.winWr;

  always_comb begin
    busRdata = '0;
    if (strb.ctrlRd) begin
      busRdata[FIRST_LSB +: IDX_W] = firstIdx;
      busRdata[LEN_LSB +: IDX_W]   = burstLen;
    end else if (strb.winRd) begin
      busRdata[WIN_W-1:0] = regRdata;
    end
  end

  // R2
  ctrl_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlWr |=> (firstIdx == $past(busWdata[FIRST_LSB +: IDX_W]) &&
                     burstLen == $past(busWdata[LEN_LSB +: IDX_W])));

  // R9
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ctrlWr |=> ($stable(firstIdx) && $stable(burstLen)));

endmodule

// File: rtl/tmr_burst_redirect.sv
module tmr_burst_redirect
  import tbr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5,
  parameter int WIN_W     = 16,
  parameter int LEN_LSB   = 8,
  parameter int FIRST_LSB = 0,
  parameter int CTRL_OFF  = 'h48,
  parameter int WIN_OFF   = 'h4C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [IDX_W-1:0]  regSel,
  output logic [WIN_W-1:0]  regWdata,
  output logic              regWe,
  input  logic [WIN_W-1:0]  regRdata
);

  tbr_strobe_t      strb;
  logic [IDX_W-1:0] stepCnt;
  logic [IDX_W-1:0] burstLen;

  tbr_ctrl #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .CTRL_OFF(CTRL_OFF),
    .WIN_OFF (WIN_OFF)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busValid(busValid),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .burstLen(burstLen),
    .strb    (strb),
    .stepCnt (stepCnt)
  );

  tbr_datapath #(
    .DATA_W   (DATA_W),
    .IDX_W    (IDX_W),
    .WIN_W    (WIN_W),
    .LEN_LSB  (LEN_LSB),
    .FIRST_LSB(FIRST_LSB)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busWdata(busWdata),
    .stepCnt (stepCnt),
    .regRdata(regRdata),
    .busRdata(busRdata),
    .regSel  (regSel),
    .regWdata(regWdata),
    .regWe   (regWe),
    .burstLen(burstLen)
  );

  // R7
  win_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> (busValid && busWrite && busAddr == ADDR_W'(WIN_OFF)));

  // R6
  win_rd_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite && busAddr == ADDR_W'(WIN_OFF)) |->
      (busRdata[DATA_W-1:WIN_W] == '0 && busRdata[WIN_W-1:0] == regRdata));

endmodule

// File: tb/tmr_burst_redirect_tb.sv
`timescale 1ns/1ps
module tmr_burst_redirect_tb;

  localparam logic [7:0] A_CTRL = 8'h48;
  localparam logic [7:0] A_WIN  = 8'h4C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [4:0]  regSel;
  logic [15:0] regWdata;
  logic        regWe;
  logic [15:0] regRdata;

  int nTests = 0;
  int nFails = 0;
  bit finished = 0;

  logic [15:0] tfile [32];
  logic [15:0] mFile [32];
  logic [4:0]  mFirst, mLen, mStep;

  always #2.5 clk = ~clk;

  tmr_burst_redirect u_dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .regSel(regSel), .regWdata(regWdata), .regWe(regWe), .regRdata(regRdata)
  );

  // Backing timer registers.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 32; i++) tfile[i] <= 16'hA500 + 16'(i) * 16'h0101;
    end else if (regWe) begin
      tfile[regSel] <= regWdata;
    end
  end
  assign regRdata = tfile[regSel];

  function automatic logic [4:0] expSel();
    return mFirst + mStep;
  endfunction

  function automatic logic [31:0] expCtrl();
    return {19'd0, mLen, 3'd0, mFirst};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One bus access, checked against the model, then the model is updated.
  task automatic doOp(input logic wr, input logic [7:0] addr, input logic [31:0] wd, input string selTag);
    logic [31:0] rd;
    logic [4:0]  sel;
    logic        we;
    logic [15:0] wdat;
    logic [4:0]  es;
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busWdata = wd;
    #1;
    rd = busRdata; sel = regSel; we = regWe; wdat = regWdata;
    es = expSel();
    if (addr == A_WIN) begin
      check(sel == es, selTag, 32'(sel), 32'(es));
      check(we == wr, "R7 strobe", 32'(we), 32'(wr));
      if (wr) check(wdat == wd[15:0], "R7 data", 32'(wdat), 32'(wd[15:0]));
      else check(rd == {16'd0, mFile[es]}, "R6 read", rd, {16'd0, mFile[es]});
    end else begin
      check(we == 1'b0, (addr == A_CTRL) ? "R7 no strobe" : "R9 no strobe", 32'(we), 0);
      if (!wr) begin
        if (addr == A_CTRL) check(rd == expCtrl(), "R2 readback", rd, expCtrl());
        else check(rd == 0, "R9 read zero", rd, 0);
      end
    end
    @(posedge clk);
    #1;
    busValid = 1'b0; busWrite = 1'b0;
    if (addr == A_WIN) begin
      if (wr) mFile[es] = wd[15:0];
      mStep = (mStep == mLen) ? 5'd0 : mStep + 5'd1;
    end else if (addr == A_CTRL && wr) begin
      mFirst = wd[4:0]; mLen = wd[12:8]; mStep = 5'd0;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFails++; nTests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mFile[i] = 16'hA500 + 16'(i) * 16'h0101;
    mFirst = 0; mLen = 0; mStep = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state of control word and first target.
    doOp(1'b0, A_CTRL, 0, "R1");
    check(expCtrl() == 0, "R1 model", expCtrl(), 0);
    doOp(1'b0, A_WIN, 0, "R1 first index");

    // R2: reserved bits ignored on write, read back as zero.
    doOp(1'b1, A_CTRL, 32'hFFFF_E2E3, "R2");
    doOp(1'b0, A_CTRL, 0, "R2");

    // R3, R4: two full bursts of three.
    for (int k = 0; k < 6; k++) doOp(1'b0, A_WIN, 0, "R3 R4 sequence");

    // R7 write mid-burst, then R5 clear via control write.
    doOp(1'b1, A_WIN, 32'hDEAD_1234, "R7 target");
    doOp(1'b1, A_CTRL, 32'h0000_0107, "R5 clear");
    doOp(1'b0, A_WIN, 0, "R5 restart at new first index");
    doOp(1'b0, A_WIN, 0, "R5 second step");

    // R8: wrap past index 31.
    doOp(1'b1, A_CTRL, 32'h0000_041E, "R8");
    for (int k = 0; k < 5; k++) doOp(1'b1, A_WIN, 32'h0000_7700 + 32'(k), "R8 wrap");
    for (int k = 0; k < 5; k++) doOp(1'b0, A_WIN, 0, "R8 wrap readback");

    // R9: other addresses leave state alone.
    doOp(1'b0, A_WIN, 0, "R9 before");
    doOp(1'b1, 8'h4D, 32'hFFFF_FFFF, "R9");
    doOp(1'b1, 8'h49, 32'h0000_1F1F, "R9");
    doOp(1'b0, 8'h40, 0, "R9");
    doOp(1'b0, A_WIN, 0, "R9 counter unchanged");
    doOp(1'b0, A_CTRL, 0, "R9 control unchanged");

    // Constrained random traffic.
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 400; n++) begin
      int pick = int'($urandom_range(0, 9));
      logic [7:0] a;
      if (pick < 6) a = A_WIN;
      else if (pick < 8) a = A_CTRL;
      else a = 8'h40 + 8'($urandom_range(0, 15));
      doOp(1'($urandom_range(0, 1)), a, $urandom(), "R3 R8 random");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule